// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers level-sensitive interrupt lines from across the chip into groups of thirty-two. Each group has its own enable mask. Software never rewrites a whole mask word to change one line: it writes ones to a set port to block lines and ones to a clear port to let them through. For each group the block shows the asserted lines that are not blocked as one pending word, so an interrupt handler can see at a glance whether any group needs service.

Every input has a small priority value. Among the unmasked asserted lines whose priority is below a programmable threshold, the block picks one winner and captures its number into an active register, then raises one interrupt line to the processor. The captured number stays fixed until software writes an agreement bit. After that write the block is free to choose the next winner. The same write also clears a capture whose source has since gone away or been masked.

A software-triggered soft reset returns the masks, priorities, threshold and capture to their initial state and reports completion through a done flag. A configuration bit for automatic idling is kept and is set again when the reset finishes. Access is through a plain register port: a write strobe, an address and write data, with read data driven combinationally from the address.

Top module: `intc_banked`

## Requirements
- R1: After hardware reset, irq_o is 0, the status word (0x14) reads 1, the configuration word (0x10) reads 1, every mask word reads all ones, the threshold (0x68) reads all ones and the active register (0x40) reads 0.
- R2: For group g, the mask word is at 0x84+0x20*g, and a 1 bit in it blocks that line. Writing ones to 0x88+0x20*g clears those mask bits. Writing ones to 0x8C+0x20*g sets them. Zero bits in either write leave the mask unchanged.
- R3: The pending word at 0x98+0x20*g reads as the group's asserted lines AND NOT its mask, whatever the priorities and threshold are.
- R4: A line can win only if it is asserted, unmasked and has a priority strictly below the threshold. The lowest priority value wins, and on a tie the lowest line number wins.
- R5: If nothing is captured and a winner exists, the winner's number is captured at the next clock edge and irq_o goes to 1. Bits 6:0 of 0x40 read the captured number and read 0 while nothing is captured.
- R6: While a capture is held, the captured number and irq_o do not change, even if the inputs change or the captured line drops.
- R7: Writing 1 to bit 0 of 0x48 drops the capture, so irq_o is 0 after that edge. A new winner is captured one edge later, and a stale capture with no remaining winner leaves irq_o at 0.
- R8: Writing 1 to bit 1 of 0x10 masks every line, sets every priority to 0, sets the threshold to all ones and drops the capture. Bit 0 of 0x14 reads 0 right after that write and reads 1 from the second following clock edge.
- R9: Bit 0 of 0x10 is a read/write idle-enable bit that becomes 1 when a soft reset completes. Bit 1 always reads 0.
- R10: The word at 0x00 reads the major revision in bits 7:4 and the minor revision in bits 3:0.
- R11: The priority of line n is read/write at 0x100+4*n. It keeps only the low PRIO_W bits of the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32*NUM_BANKS | Level interrupt lines, line n on bit n |
| bus_wr | input | 1 | Register write strobe, taken at the clock edge |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request to the processor, high while a capture is held |

## Verification
The bench builds the block with four groups, which gives 128 lines and PRIO_W of 6. It can therefore drive line numbers that need all seven bits of the active field. It also reaches a fourth group whose mask, pending and priority registers sit at the top of the address map. Pairs of lines are placed in the same group and in different groups to exercise priority ordering, tie-breaking and the strict threshold comparison at its boundary. The threshold is left at its maximum so that a priority of 63 is shown to stay ineligible.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int BANK_W      = 32;
   localparam int ACT_FIELD_W = 7;

   localparam int OFS_REV     = 'h000;
   localparam int OFS_CFG     = 'h010;
   localparam int OFS_STAT    = 'h014;
   localparam int OFS_ACT     = 'h040;
   localparam int OFS_CTRL    = 'h048;
   localparam int OFS_THR     = 'h068;
   localparam int OFS_BANK    = 'h080;
   localparam int BANK_STRIDE = 'h020;
   localparam int SUB_MASK    = 'h04;
   localparam int SUB_CLR     = 'h08;
   localparam int SUB_SET     = 'h0C;
   localparam int SUB_PEND    = 'h18;
   localparam int OFS_PRIO    = 'h100;

   // captured source: valid flag plus number field
   typedef struct packed {
      logic                   valid;
      logic [ACT_FIELD_W-1:0] num;
   } act_latch_t;

   function automatic int bank_reg(input int bank, input int sub);
      return OFS_BANK + BANK_STRIDE * bank + sub;
   endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         wr_direct,
   input  logic         wr_clr,
   input  logic         wr_set,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] irq_raw,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] pending
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= '1;
      else if (soft_clr)   mask_q <= '1;
      else if (wr_direct)  mask_q <= wdata;
      else if (wr_clr)     mask_q <= mask_q & ~wdata;
      else if (wr_set)     mask_q <= mask_q | wdata;
   end

   assign pending = irq_raw & ~mask_q;

endmodule

// File: rtl/intc_prio_file.sv
module intc_prio_file #(
   parameter int N  = 96,
   parameter int PW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_clr,
   input  logic [N-1:0]  wr_en,
   input  logic [PW-1:0] wdata,
   output logic [PW-1:0] prio_q [N]
);

   for (genvar g = 0; g < N; g++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         prio_q[g] <= '0;
         else if (soft_clr)  prio_q[g] <= '0;
         else if (wr_en[g])  prio_q[g] <= wdata;
      end
   end

endmodule

// File: rtl/intc_prio_select.sv
module intc_prio_select #(
   parameter int N  = 96,
   parameter int PW = 6,
   parameter int IW = 7
) (
   input  logic [N-1:0]  cand,
   input  logic [PW-1:0] prio_q [N],
   input  logic [PW-1:0] thresh,
   output logic          found,
   output logic [IW-1:0] win_idx
);

   logic [PW-1:0] best;

   // strict less-than keeps the lowest index on equal priority
   always_comb begin
      found   = 1'b0;
      best    = '1;
      win_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (prio_q[i] < thresh) && (!found || (prio_q[i] < best))) begin
            found   = 1'b1;
            best    = prio_q[i];
            win_idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/intc_banked.sv
module intc_banked
   import intc_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 6,
   parameter int ADDR_W    = 10,
   parameter int RESET_LAT = 2,
   parameter int REV_MAJOR = 5,
   parameter int REV_MINOR = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*32-1:0]     irq_in,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   output logic                        irq_o
);

   localparam int NUM_SRC = NUM_BANKS * BANK_W;
   localparam int IDX_W   = $clog2(NUM_SRC);
   localparam int CNT_W   = $clog2(RESET_LAT + 1);
   localparam int TOP_A   = OFS_PRIO + 4 * NUM_SRC;

   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..4");
   end
   if (PRIO_W < 2 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 2..8");
   end
   if (RESET_LAT < 1) begin : g_bad_lat
      $error("RESET_LAT must be at least 1");
   end
   if ((1 << ADDR_W) < TOP_A) begin : g_bad_addr
      $error("ADDR_W too narrow for the priority window");
   end
   if (IDX_W > ACT_FIELD_W) begin : g_bad_idx
      $error("source number exceeds the active field");
   end

   // ---------------- decode ----------------
   logic cfg_wr, soft_go, agree, thr_wr;
   assign cfg_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
   assign soft_go = cfg_wr && bus_wdata[1];
   assign agree   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[0];
   assign thr_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_THR));

   // ---------------- configuration and soft reset ----------------
   logic              autoidle_q, done_q, busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PRIO_W-1:0] thresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autoidle_q <= 1'b1;
         done_q     <= 1'b1;
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         thresh_q   <= '1;
      end else begin
         if (cfg_wr) autoidle_q <= bus_wdata[0];
         if (thr_wr) thresh_q <= bus_wdata[PRIO_W-1:0];
         if (soft_go) begin
            done_q   <= 1'b0;
            busy_q   <= 1'b1;
            cnt_q    <= CNT_W'(RESET_LAT - 1);
            thresh_q <= '1;
         end else if (busy_q) begin
            if (cnt_q == '0) begin
               busy_q     <= 1'b0;
               done_q     <= 1'b1;
               autoidle_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   // ---------------- mask groups ----------------
   logic [BANK_W-1:0]  bank_mask [NUM_BANKS];
   logic [BANK_W-1:0]  bank_pend [NUM_BANKS];
   logic [NUM_SRC-1:0] pend_all;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic wr_direct, wr_clr, wr_set;
      assign wr_direct = bus_wr && (bus_addr == ADDR_W'(bank_reg(g, SUB_MASK)));
      assign wr_clr    = bus_wr && (bus_addr == ADDR_W'(bank_reg(g, SUB_CLR)));
      assign wr_set    = bus_wr && (bus_addr == ADDR_W'(bank_reg(g, SUB_SET)));

      intc_mask_bank #(.W(BANK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_clr  (soft_go),
         .wr_direct (wr_direct),
         .wr_clr    (wr_clr),
         .wr_set    (wr_set),
         .wdata     (bus_wdata),
         .irq_raw   (irq_in[g*BANK_W +: BANK_W]),
         .mask_q    (bank_mask[g]),
         .pending   (bank_pend[g])
      );
      assign pend_all[g*BANK_W +: BANK_W] = bank_pend[g];
   end

   // ---------------- priorities ----------------
   logic [NUM_SRC-1:0] prio_we;
   logic [PRIO_W-1:0]  prio_q [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_pwe
      assign prio_we[s] = bus_wr && (bus_addr == ADDR_W'(OFS_PRIO + 4 * s));
   end

   intc_prio_file #(.N(NUM_SRC), .PW(PRIO_W)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_go),
      .wr_en    (prio_we),
      .wdata    (bus_wdata[PRIO_W-1:0]),
      .prio_q   (prio_q)
   );

   // ---------------- selection and capture ----------------
   logic             found;
   logic [IDX_W-1:0] win_idx;

   intc_prio_select #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_sel (
      .cand    (pend_all),
      .prio_q  (prio_q),
      .thresh  (thresh_q),
      .found   (found),
      .win_idx (win_idx)
   );

   act_latch_t act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (soft_go || agree) begin
         act_q <= '0;
      end else if (!act_q.valid && found) begin
         act_q.valid <= 1'b1;
         act_q.num   <= ACT_FIELD_W'(win_idx);
      end
   end

   assign irq_o = act_q.valid;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_REV))  bus_rdata[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
      if (bus_addr == ADDR_W'(OFS_CFG))  bus_rdata[0] = autoidle_q;
      if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata[0] = done_q;
      if (bus_addr == ADDR_W'(OFS_ACT))  bus_rdata[ACT_FIELD_W-1:0] = act_q.num;
      if (bus_addr == ADDR_W'(OFS_THR))  bus_rdata[PRIO_W-1:0] = thresh_q;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(bank_reg(b, SUB_MASK))) bus_rdata = bank_mask[b];
         if (bus_addr == ADDR_W'(bank_reg(b, SUB_PEND))) bus_rdata = bank_pend[b];
      end
      for (int s = 0; s < NUM_SRC; s++) begin
         if (bus_addr == ADDR_W'(OFS_PRIO + 4 * s)) bus_rdata[PRIO_W-1:0] = prio_q[s];
      end
   end

endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk
   import intc_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq_o,
   input act_latch_t        act_q,
   input logic [31:0]       mask_b0,
   input logic              found,
   input logic              done_q
);

   logic agree_w, sr_w, clr0_w, set0_w;
   assign agree_w = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[0];
   assign sr_w    = bus_wr && (bus_addr == ADDR_W'(OFS_CFG)) && bus_wdata[1];
   assign clr0_w  = bus_wr && (bus_addr == ADDR_W'(bank_reg(0, SUB_CLR)));
   assign set0_w  = bus_wr && (bus_addr == ADDR_W'(bank_reg(0, SUB_SET)));

   // R7
   agree_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      agree_w |=> !irq_o);

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !agree_w && !sr_w) |=> (irq_o && $stable(act_q)));

   // R5
   rise_needs_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(found));

   // R8
   sr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_w |=> (!done_q && !irq_o));

   // R8
   sr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_w ##1 !sr_w ##1 !sr_w |=> done_q);

   // R2
   clr_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr0_w |=> ((mask_b0 & $past(bus_wdata)) == 32'h0));

   // R2
   set_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set0_w |=> ((mask_b0 & $past(bus_wdata)) == $past(bus_wdata)));

endmodule

bind intc_banked intc_banked_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .act_q     (act_q),
   .mask_b0   (bank_mask[0]),
   .found     (found),
   .done_q    (done_q)
);

// File: tb/intc_banked_test.sv
`timescale 1ns/1ps
module intc_banked_test;

   localparam int NB  = 4;
   localparam int NS  = NB * 32;
   localparam int AW  = 10;
   localparam int CFG = 'h10, STAT = 'h14, ACT = 'h40, CTRL = 'h48, THR = 'h68;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   intc_banked #(.NUM_BANKS(NB), .PRIO_W(6), .ADDR_W(AW), .RESET_LAT(2),
                 .REV_MAJOR(5), .REV_MINOR(1)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // {src a, prio a, src b, prio b, threshold, expected irq, expected number}
   localparam logic [39:0] VEC [8] = '{
      {7'd5,   6'd3,  7'd40,  6'd1,  6'd63, 1'b1, 7'd40},
      {7'd5,   6'd2,  7'd40,  6'd2,  6'd63, 1'b1, 7'd5},
      {7'd100, 6'd7,  7'd127, 6'd7,  6'd63, 1'b1, 7'd100},
      {7'd10,  6'd9,  7'd70,  6'd4,  6'd5,  1'b1, 7'd70},
      {7'd10,  6'd9,  7'd70,  6'd5,  6'd5,  1'b0, 7'd0},
      {7'd127, 6'd0,  7'd0,   6'd1,  6'd63, 1'b1, 7'd127},
      {7'd33,  6'd62, 7'd64,  6'd63, 6'd63, 1'b1, 7'd33},
      {7'd96,  6'd20, 7'd95,  6'd20, 6'd63, 1'b1, 7'd95}
   };

   function automatic int breg(input int b, input int sub);
      return 'h80 + 'h20 * b + sub;
   endfunction

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      #(8 * 60000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R10 revision
      chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
      rd(STAT, d);  chk("R1 status", d, 32'h1);
      rd(CFG, d);   chk("R1 config", d, 32'h1);
      rd(breg(3, 4), d); chk("R1 mask group3", d, 32'hFFFF_FFFF);
      rd(THR, d);   chk("R1 threshold", d, 32'h3F);
      rd(ACT, d);   chk("R1 active", d, 32'h0);
      rd('h00, d);  chk("R10 revision", d, 32'h51);

      // R4 R5 table of source pairs
      for (int v = 0; v < 8; v++) begin
         logic [39:0] e;
         logic [6:0]  sa, sb;
         e  = VEC[v];
         sa = e[39:33];
         sb = e[26:20];
         wr(THR, {26'b0, e[13:8]});
         wr('h100 + 4 * int'(sa), {26'b0, e[32:27]});
         wr('h100 + 4 * int'(sb), {26'b0, e[19:14]});
         wr(breg(int'(sa) >> 5, 8), 32'h1 << sa[4:0]);
         wr(breg(int'(sb) >> 5, 8), 32'h1 << sb[4:0]);
         irq_in = '0; irq_in[sa] = 1'b1; irq_in[sb] = 1'b1;
         @(negedge clk);
         chk($sformatf("R4 R5 vector %0d irq", v), {31'b0, irq_o}, {31'b0, e[7]});
         rd(ACT, d);
         chk($sformatf("R4 R5 vector %0d number", v), d, {25'b0, e[6:0]});
         irq_in = '0;
         wr(breg(int'(sa) >> 5, 'hC), 32'h1 << sa[4:0]);
         wr(breg(int'(sb) >> 5, 'hC), 32'h1 << sb[4:0]);
         wr(CTRL, 32'h1);
      end
      wr(THR, 32'h3F);

      // R2 write-one clear and set
      wr(breg(0, 8), 32'h0000_00F0);
      rd(breg(0, 4), d); chk("R2 clear", d, 32'hFFFF_FF0F);
      wr(breg(0, 'hC), 32'h0000_0030);
      rd(breg(0, 4), d); chk("R2 set", d, 32'hFFFF_FF3F);

      // R3 pending word
      irq_in[7:4] = 4'hF;
      rd(breg(0, 'h18), d); chk("R3 pending", d, 32'h0000_00C0);
      rd(breg(1, 'h18), d); chk("R3 pending other group", d, 32'h0);
      @(negedge clk);
      rd(ACT, d); chk("R5 tie captured", d, 32'd6);

      // R6 hold while inputs change
      irq_in[7:4] = 4'h8;
      @(negedge clk);
      rd(ACT, d); chk("R6 number held", d, 32'd6);
      chk("R6 irq held", {31'b0, irq_o}, 32'h1);

      // R7 agreement then recapture
      wr(CTRL, 32'h1);
      chk("R7 irq dropped", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      rd(ACT, d); chk("R7 next captured", d, 32'd7);

      // R7 stale capture
      irq_in = '0;
      @(negedge clk);
      chk("R6 stale still held", {31'b0, irq_o}, 32'h1);
      wr(CTRL, 32'h1);
      repeat (3) @(negedge clk);
      chk("R7 stale cleared", {31'b0, irq_o}, 32'h0);
      rd(ACT, d); chk("R7 active idle", d, 32'h0);

      // R11 priority width
      wr('h234, 32'h2A);
      rd('h234, d); chk("R11 readback", d, 32'h2A);
      wr('h234, 32'hFF);
      rd('h234, d); chk("R11 truncation", d, 32'h3F);

      // R9 idle-enable bit
      wr(CFG, 32'h0);
      rd(CFG, d); chk("R9 write 0", d, 32'h0);

      // R8 soft reset with a capture held
      wr(breg(3, 8), 32'h1);
      irq_in[96] = 1'b1;
      @(negedge clk);
      chk("R8 capture before reset", {31'b0, irq_o}, 32'h1);
      wr(CFG, 32'h2);
      rd(STAT, d); chk("R8 busy after write", d, 32'h0);
      chk("R8 capture dropped", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      rd(STAT, d); chk("R8 busy one edge later", d, 32'h0);
      @(negedge clk);
      rd(STAT, d); chk("R8 done two edges later", d, 32'h1);
      rd(CFG, d);  chk("R9 idle set after reset", d, 32'h1);
      rd(breg(3, 4), d); chk("R8 masks restored", d, 32'hFFFF_FFFF);
      rd('h234, d); chk("R8 priority cleared", d, 32'h0);
      rd(THR, d);  chk("R8 threshold restored", d, 32'h3F);
      chk("R8 masked line ignored", {31'b0, irq_o}, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule